// File: doc/BRIEF.md
# Serial Register Write and Readback Engine

This block is a serial bus master for a target device that takes 32-bit configuration words and returns 12-bit status words. It drives a serial clock, a latch-enable strobe and a data-out line, and it samples a data-in line. The target uses that data-in line both as a multiplexed output and as the readback path. A host starts a single transfer with a one-cycle command. The command chooses between a write, which shifts a word out and latches it, and a read, which collects a readback word. The host then waits for the done pulse.

A write keeps latch-enable low while the 32 data bits shift out, most significant bit first, one bit per serial clock period. Latch-enable then pulses high so that the target takes the word. A read raises latch-enable and keeps it high for the whole transfer. The target launches each data bit on a rising serial clock edge, and the engine captures that bit on the next falling edge. The minimum intervals of the serial bus are given in nanoseconds, together with the system clock frequency. Each interval is turned into a whole number of system clock cycles, rounded up.

The bit encoding is fixed. `cmd_read_i`=1 selects a read and 0 selects a write. Bits go out and come in most significant bit first. The first captured readback bit lands in `rd_data_o[11]`. With the default parameters (100 MHz system clock; 15, 15, 25, 25 and 10 ns intervals) these interval lengths apply: latch-to-clock setup 2 cycles, clock high 3, clock low 3, end-of-read hold 1.

Top module: `srb_engine`

## Requirements
- R1: After reset and whenever idle, `sclk_o`, `le_o`, `sdo_o`, `busy_o` and `done_o` are low, and `rd_data_o` is zero after reset.
- R2: A `cmd_valid_i` sampled while `busy_o` is low starts a transfer, and `busy_o` is high from the next cycle. `cmd_read_i`=1 selects a read and 0 selects a write.
- R3: A write shifts out `wr_data_i` bit 31 first through bit 0 on `sdo_o`, one bit per clock rise, for exactly 32 rises. `sdo_o` changes only while `sclk_o` is low, and `le_o` stays low throughout.
- R4: After the last write clock falls, `le_o` goes high for exactly high-time plus low-time cycles (6 by default) with `sclk_o` low, then returns low.
- R5: A read raises `le_o` at least setup cycles (2 by default) before the first `sclk_o` rise. `le_o` stays high through exactly 12 clock rises.
- R6: During a read, `sdi_i` is sampled at each falling edge of `sclk_o`. The first sample goes to bit 11 and the last to bit 0. `rd_data_o` takes the new word in the cycle `done_o` is high.
- R7: Every `sclk_o` high phase lasts at least the larger of the high-time and data-valid cycle counts. Every low phase between two rises lasts at least the low-time cycle count (3 and 3 by default).
- R8: In a read, `le_o` falls exactly low-time plus hold cycles (4 by default) after the last falling edge of `sclk_o`.
- R9: `busy_o` lasts 32·(hi+lo)+(hi+lo) cycles for a write (198 by default) and setup+12·(rhi+lo)+hold cycles for a read (75 by default). Here rhi is the longer of the high-time and data-valid cycle counts. `done_o` is a one-cycle pulse in the first cycle with `busy_o` low.
- R10: `cmd_valid_i` is ignored while `busy_o` is high. The running transfer, its written word and its length are unchanged, and no new transfer follows.
- R11: A write leaves `rd_data_o` unchanged.
- R12: Each interval equals ceil(ns × CLK_HZ / 1e9) cycles, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start-transfer strobe |
| cmd_read_i | input | 1 | 1 = read, 0 = write |
| wr_data_i | input | 32 | Word to write, sampled with the command |
| rd_data_o | output | 12 | Last readback word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| sclk_o | output | 1 | Serial clock |
| le_o | output | 1 | Latch-enable strobe |
| sdo_o | output | 1 | Serial data to target |
| sdi_i | input | 1 | Serial data from target |

## Verification
Several properties are checked on every cycle. The bus is quiet when idle. Data-out is steady while the clock is high. Every clock high phase meets its minimum length. Latch-enable is high for at least the setup count before a clock rise under latch-enable. The done pulse is one cycle long and ends the busy window. The readback register moves only with done. The directed scenarios cover what only a complete transfer can show, using a bench model of the target that captures written bits and launches readback bits. That covers word content and bit order, exact rise counts, the latch pulse length, the end-of-read hold, exact busy lengths, commands ignored while busy, and readback kept across writes.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_LO,
    ST_W_HI,
    ST_W_LATCH,
    ST_R_SETUP,
    ST_R_HI,
    ST_R_LO,
    ST_R_TAIL
  } srb_state_e;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned hz);
    longint unsigned c;
    c = (64'(ns) * 64'(hz) + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srb_timer.sv
module srb_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/srb_shift.sv
module srb_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic         msb_o,
  output logic [W-1:0] par_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= load_val_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], ser_i};
  end

  assign msb_o = sr_q[W-1];
  assign par_o = sr_q;
endmodule

// File: rtl/srb_engine.sv
module srb_engine
  import srb_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned WR_W        = 32,
  parameter int unsigned RD_W        = 12,
  parameter int unsigned T_SETUP_NS  = 15,
  parameter int unsigned T_VALID_NS  = 15,
  parameter int unsigned T_HI_NS     = 25,
  parameter int unsigned T_LO_NS     = 25,
  parameter int unsigned T_HOLD_NS   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic            cmd_read_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            sclk_o,
  output logic            le_o,
  output logic            sdo_o,
  input  logic            sdi_i
);
  localparam int unsigned C_SETUP = ns_to_cyc(T_SETUP_NS, CLK_HZ);
  localparam int unsigned C_VALID = ns_to_cyc(T_VALID_NS, CLK_HZ);
  localparam int unsigned C_HI    = ns_to_cyc(T_HI_NS, CLK_HZ);
  localparam int unsigned C_LO    = ns_to_cyc(T_LO_NS, CLK_HZ);
  localparam int unsigned C_HOLD  = ns_to_cyc(T_HOLD_NS, CLK_HZ);
  localparam int unsigned C_RHI   = max_u(C_HI, C_VALID);
  localparam int unsigned C_LATCH = C_HI + C_LO;
  localparam int unsigned C_MAX   = max_u(max_u(C_SETUP, C_RHI), max_u(max_u(C_LO, C_HOLD), C_LATCH));
  localparam int unsigned CW      = $clog2(C_MAX + 1);
  localparam int unsigned BCW     = $clog2(max_u(WR_W, RD_W) + 1);

  srb_state_e     st_q, st_d;
  logic [BCW-1:0] bit_q;
  logic           bit_clr, bit_inc;
  logic           tmr_ld, tmr_zero;
  logic [CW-1:0]  tmr_val;
  logic           wr_ld, wr_shift, wr_msb;
  logic           rd_shift;
  logic [RD_W-1:0] rd_par;
  logic           fin, rd_fin;
  logic [WR_W-1:0] wr_par_unused;
  logic           rd_msb_unused;
  logic [RD_W-1:0] rd_q;
  logic           done_q;

  srb_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  srb_shift #(.W(WR_W)) u_wr_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_ld),
    .load_val_i (wr_data_i),
    .shift_i    (wr_shift),
    .ser_i      (1'b0),
    .msb_o      (wr_msb),
    .par_o      (wr_par_unused)
  );

  srb_shift #(.W(RD_W)) u_rd_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (1'b0),
    .load_val_i ('0),
    .shift_i    (rd_shift),
    .ser_i      (sdi_i),
    .msb_o      (rd_msb_unused),
    .par_o      (rd_par)
  );

  always_comb begin
    st_d     = st_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    wr_ld    = 1'b0;
    wr_shift = 1'b0;
    rd_shift = 1'b0;
    bit_clr  = 1'b0;
    bit_inc  = 1'b0;
    fin      = 1'b0;
    rd_fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid_i) begin
        bit_clr = 1'b1;
        tmr_ld  = 1'b1;
        if (cmd_read_i) begin
          st_d    = ST_R_SETUP;
          tmr_val = CW'(C_SETUP - 1);
        end else begin
          st_d    = ST_W_LO;
          tmr_val = CW'(C_LO - 1);
          wr_ld   = 1'b1;
        end
      end
      ST_W_LO: if (tmr_zero) begin
        st_d    = ST_W_HI;
        tmr_ld  = 1'b1;
        tmr_val = CW'(C_HI - 1);
      end
      ST_W_HI: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (bit_q == BCW'(WR_W - 1)) begin
          st_d    = ST_W_LATCH;
          tmr_val = CW'(C_LATCH - 1);
        end else begin
          st_d     = ST_W_LO;
          tmr_val  = CW'(C_LO - 1);
          wr_shift = 1'b1;
          bit_inc  = 1'b1;
        end
      end
      ST_W_LATCH: if (tmr_zero) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      ST_R_SETUP: if (tmr_zero) begin
        st_d    = ST_R_HI;
        tmr_ld  = 1'b1;
        tmr_val = CW'(C_RHI - 1);
      end
      ST_R_HI: if (tmr_zero) begin
        // clock falls on this edge; capture the bit launched at the rise
        st_d     = ST_R_LO;
        tmr_ld   = 1'b1;
        tmr_val  = CW'(C_LO - 1);
        rd_shift = 1'b1;
      end
      ST_R_LO: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (bit_q == BCW'(RD_W - 1)) begin
          st_d    = ST_R_TAIL;
          tmr_val = CW'(C_HOLD - 1);
        end else begin
          st_d    = ST_R_HI;
          tmr_val = CW'(C_RHI - 1);
          bit_inc = 1'b1;
        end
      end
      ST_R_TAIL: if (tmr_zero) begin
        st_d   = ST_IDLE;
        fin    = 1'b1;
        rd_fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (bit_clr)      bit_q <= '0;
      else if (bit_inc) bit_q <= bit_q + 1'b1;
      if (rd_fin)       rd_q <= rd_par;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_data_o = rd_q;
  assign sclk_o    = (st_q == ST_W_HI) || (st_q == ST_R_HI);
  assign le_o      = (st_q == ST_W_LATCH) || (st_q == ST_R_SETUP) || (st_q == ST_R_HI) ||
                     (st_q == ST_R_LO) || (st_q == ST_R_TAIL);
  assign sdo_o     = ((st_q == ST_W_LO) || (st_q == ST_W_HI)) && wr_msb;
endmodule

// File: rtl/srb_engine_chk.sv
module srb_engine_chk #(
  parameter int unsigned RD_W      = 12,
  parameter int unsigned HI_MIN    = 1,
  parameter int unsigned SETUP_MIN = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            sclk_o,
  input logic            le_o,
  input logic            sdo_o,
  input logic [RD_W-1:0] rd_data_o
);
  logic [15:0] hi_run, le_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      le_run <= '0;
    end else begin
      hi_run <= sclk_o ? ((hi_run == 16'hffff) ? hi_run : hi_run + 1'b1) : '0;
      le_run <= le_o   ? ((le_run == 16'hffff) ? le_run : le_run + 1'b1) : '0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !le_o && !sdo_o));

  p_sdo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o));

  p_le_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && le_o) |-> (le_run >= 16'(SETUP_MIN)));

  p_hi_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_run >= 16'(HI_MIN)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rd_data_o));
endmodule

bind srb_engine srb_engine_chk #(
  .RD_W      (RD_W),
  .HI_MIN    (C_RHI),
  .SETUP_MIN (C_SETUP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sclk_o    (sclk_o),
  .le_o      (le_o),
  .sdo_o     (sdo_o),
  .rd_data_o (rd_data_o)
);

// File: tb/tb_srb_engine.sv
module tb_srb_engine;
  localparam int CLK_P = 10;
  localparam int HZ    = 100_000_000;

  function automatic int cyc(int ns);
    int c;
    c = int'((64'(ns) * 64'(HZ) + 64'd999_999_999) / 64'd1_000_000_000);
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_SETUP = 2, E_HI = 3, E_LO = 3, E_HOLD = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0, sdi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_data;
  logic        busy, done, sclk, le, sdo;

  always #(CLK_P/2) clk = ~clk;

  srb_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_read_i(cmd_read),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .busy_o(busy), .done_o(done),
    .sclk_o(sclk), .le_o(le), .sdo_o(sdo), .sdi_i(sdi)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model
  logic [11:0] rb_pat = '0;
  logic [31:0] cap_w = '0;
  int w_rises = 0, r_rises = 0;

  always @(posedge sclk) begin
    if (le) begin
      sdi <= (r_rises < 12) ? rb_pat[11 - r_rises] : 1'b0;
      r_rises <= r_rises + 1;
    end else begin
      cap_w   <= {cap_w[30:0], sdo};
      w_rises <= w_rises + 1;
    end
  end

  // timing monitor, sampled mid-cycle
  int busy_cnt, hi_run, lo_run, le_run, since_fall, min_hi, min_lo, setup, tail, le_len, op_rises;
  logic ps = 0, pl = 0;

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (sclk && !ps) begin
      if (op_rises > 0 && lo_run < min_lo) min_lo = lo_run;
      if (le && op_rises == 0) setup = le_run;
      op_rises++;
    end
    if (!sclk && ps && hi_run < min_hi) min_hi = hi_run;
    if (!le && pl) begin
      le_len = le_run;
      tail   = since_fall;
    end
    since_fall = (!sclk && ps) ? 1 : since_fall + 1;
    hi_run = sclk ? (ps ? hi_run + 1 : 1) : 0;
    lo_run = !sclk ? (!ps ? lo_run + 1 : 1) : 0;
    le_run = le ? (pl ? le_run + 1 : 1) : 0;
    ps = sclk;
    pl = le;
  end

  task automatic clr_stats();
    busy_cnt = 0; min_hi = 1000; min_lo = 1000; setup = -1; tail = -1;
    le_len = -1; op_rises = 0; since_fall = 0;
    w_rises = 0; r_rises = 0;
  endtask

  task automatic issue(input bit rd, input logic [31:0] d);
    @(negedge clk);
    clr_stats();
    cmd_valid = 1'b1; cmd_read = rd; wr_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done && !busy, req, "done pulse ends busy", {done, busy}, 2);
    @(negedge clk);
    chk(!done, req, "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!sclk && !le && !sdo, "R1", "bus quiet after reset", {sclk, le, sdo}, 0);
    chk(!busy && !done, "R1", "busy/done low after reset", {busy, done}, 0);
    chk(rd_data == 0, "R1", "rd_data reset", rd_data, 0);
  endtask

  task automatic t_write(input logic [31:0] d);
    issue(1'b0, d);
    chk(busy, "R2", "busy after write command", busy, 1);
    wait_done("R9");
    chk(cap_w == d, "R3", "written word", cap_w, d);
    chk(w_rises == 32 && r_rises == 0, "R3", "write clock rises", w_rises, 32);
    chk(le_len == E_HI + E_LO, "R4", "latch pulse length", le_len, E_HI + E_LO);
    chk(busy_cnt == 32*(E_HI+E_LO) + E_HI + E_LO, "R9", "write busy length", busy_cnt, 198);
    chk(min_hi >= E_HI, "R7", "write high min", min_hi, E_HI);
    chk(min_lo >= E_LO, "R7", "write low min", min_lo, E_LO);
    chk(!sclk && !le && !sdo, "R1", "idle after write", {sclk, le, sdo}, 0);
  endtask

  task automatic t_read(input logic [11:0] p);
    rb_pat = p;
    issue(1'b1, 32'hffff_ffff);
    chk(busy && le, "R2", "read start raises busy and le", {busy, le}, 3);
    wait_done("R9");
    chk(rd_data == p, "R6", "readback word", rd_data, p);
    chk(r_rises == 12 && w_rises == 0, "R5", "read clock rises under le", r_rises, 12);
    chk(setup == E_SETUP, "R12", "le to first rise cycles", setup, E_SETUP);
    chk(tail == E_LO + E_HOLD, "R8", "last fall to le fall", tail, E_LO + E_HOLD);
    chk(le_len == busy_cnt, "R5", "le held whole read", le_len, busy_cnt);
    chk(busy_cnt == E_SETUP + 12*(E_HI+E_LO) + E_HOLD, "R9", "read busy length", busy_cnt, 75);
    chk(min_hi >= E_HI && min_lo >= E_LO, "R7", "read clock phases", min_hi, E_HI);
  endtask

  task automatic t_ignore_busy();
    issue(1'b0, 32'h1234_5678);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_read = 1'b1; wr_data = 32'hdead_beef;
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = '0;
    wait_done("R10");
    chk(cap_w == 32'h1234_5678, "R10", "word unchanged by busy cmd", cap_w, 32'h1234_5678);
    chk(busy_cnt == 198 && r_rises == 0, "R10", "length unchanged, no read", busy_cnt, 198);
    repeat (5) @(negedge clk);
    chk(!busy, "R10", "no follow-on transfer", busy, 0);
  endtask

  task automatic t_rd_hold();
    t_read(12'ha5c);
    t_write(32'h0f0f_f0f0);
    chk(rd_data == 12'ha5c, "R11", "write keeps rd_data", rd_data, 12'ha5c);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    chk(cyc(15) == E_SETUP && cyc(25) == E_HI && cyc(10) == E_HOLD, "R12",
        "bench rounding", cyc(15), E_SETUP);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(32'h8000_0001);
    t_write(32'h5a3c_e1f7);
    t_read(12'h801);
    t_read(12'h3c5);
    t_read(12'h000);
    t_read(12'hfff);
    t_ignore_busy();
    t_rd_hold();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule